// File: doc/BRIEF.md
# Device Power State and Wake Event Controller

This block holds the power state of one network controller function on a PCI bus. It also decides which kinds of bus access the function may take in each state. Configuration software writes a 2-bit target state. EEPROM-loaded capability bits say whether the optional light-sleep (D1) and deeper-sleep (D2) states exist on this part. Moves into unsupported states, and illegal moves out of D3 hot, are dropped. While the function is back in D0 but still recovering from D2 or D3 hot, every access qualifier is held low for a fixed number of cycles. Leaving D1 costs no cycles.

Three wake detectors report single-cycle pulses: pattern-frame match, magic-frame match and link status change. Each source has its own enable bit. An enabled pulse sets a sticky status bit, which software clears by writing ones. The active-low event pin is driven low while any enabled status bit is set and pin signalling is enabled. Pattern-frame wakes count only in a low-power state. Entering D3 hot clears the function's decode enables. The wake enables, pin enable and status bits survive, so a wake can still be raised from D3 hot.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After synchronous reset the state is D0 uninitialized: `pwr_state`=0, `d0_uninit`=1, `acc_cfg`=1, `acc_io`=0, `acc_mem`=0, `wake_sts`=0, `pme_n`=1, and all enables are cleared.
- R2: A power-state write uses the code 0=D0, 1=D1, 2=D2, 3=D3 hot. An accepted write shows on `pwr_state` from the next cycle.
- R3: A write of code 1 while `cap_d1`=0, or of code 2 while `cap_d2`=0, is ignored, and the current state is kept.
- R4: From D3 hot only a write of code 0 is taken. Writes of codes 1 or 2 there are ignored.
- R5: In D1, D2 and D3 hot, `acc_io` and `acc_mem` are low. Outside recovery, `acc_cfg` is high.
- R6: A command write loads the I/O and memory decode enables. In D0 outside recovery, `acc_io` follows the I/O enable and `acc_mem` follows the memory enable. A command write made in D0 clears `d0_uninit`.
- R7: D1 to D0 has no recovery. D2 to D0 holds `acc_cfg`, `acc_io` and `acc_mem` low for `D2_REC_CYC` cycles. D3 hot to D0 holds them low for `D3_REC_CYC` cycles. Every configuration write made during recovery is ignored.
- R8: Entering D3 hot clears both decode enables. Leaving D3 hot gives D0 with `d0_uninit`=1. Wake enables, pin enable and status are kept.
- R9: Wake source bit positions are 0 = pattern frame, 1 = magic frame, 2 = link change. A pulse on an enabled source sets its `wake_sts` bit in the next cycle. A pulse on a disabled source sets nothing.
- R10: A pattern-frame pulse seen while in D0 sets no status, even when enabled.
- R11: Status bits stay set until a clear write with a one in that bit position. A set and a clear of the same bit in one cycle leave it set.
- R12: `pme_n` is low exactly when pin signalling is enabled and some status bit with its source enabled is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ps_wr_en | input | 1 | Power-state write strobe |
| ps_wr_data | input | 2 | Target power-state code |
| cap_d1 | input | 1 | D1 supported (from EEPROM) |
| cap_d2 | input | 1 | D2 supported (from EEPROM) |
| cmd_wr_en | input | 1 | Command (decode enable) write strobe |
| cmd_io_en | input | 1 | I/O decode enable value |
| cmd_mem_en | input | 1 | Memory decode enable value |
| wake_en_wr | input | 1 | Wake enable register write strobe |
| wake_en_data | input | NSRC | Per-source wake enables |
| pin_en_wr | input | 1 | Pin enable write strobe |
| pin_en_data | input | 1 | Pin signalling enable value |
| sts_clr_wr | input | 1 | Status clear strobe |
| sts_clr_mask | input | NSRC | Ones clear the matching status bits |
| wake_pulse | input | NSRC | Detector pulses, one per source |
| pwr_state | output | 2 | Current power-state code |
| d0_uninit | output | 1 | In D0 with decode not yet configured |
| acc_cfg | output | 1 | Configuration accesses accepted |
| acc_io | output | 1 | I/O accesses accepted |
| acc_mem | output | 1 | Memory accesses accepted |
| wake_sts | output | NSRC | Sticky wake status |
| pme_n | output | 1 | Active-low power-management event |

## Verification
The bench builds the block with `D2_REC_CYC`=3 and `D3_REC_CYC`=9. These are short enough that both recovery windows occur many times under random power-state traffic. They also differ, so a swapped or off-by-one window count shows up on the access qualifiers. The capability bits are toggled during the run, so that both supported and unsupported D1/D2 requests occur. Configuration writes land inside recovery windows, and pattern pulses arrive in D0 as well as in the sleep states.

// File: rtl/pwr_wake_pkg.sv
// Shared types for the power state and wake controller.
// Assumes the 2-bit PCI power-state code is used unchanged on the ports.
package pwr_wake_pkg;
    typedef enum logic [1:0] {
        PS_D0 = 2'd0,
        PS_D1 = 2'd1,
        PS_D2 = 2'd2,
        PS_D3 = 2'd3
    } pstate_e;

    localparam int SRC_PATTERN = 0;
    localparam int SRC_MAGIC   = 1;
    localparam int SRC_LINK    = 2;
endpackage

// File: rtl/pwr_state_fsm.sv
// Power-state register, recovery timer and access qualifiers.
// Takes a target-state write only when no recovery window is running.
// Assumes at most one write strobe of each kind per cycle.
// Entry into D3 hot wins over a command write made in the same cycle.
module pwr_state_fsm
    import pwr_wake_pkg::*;
#(
    parameter int D2_REC_CYC = 4,
    parameter int D3_REC_CYC = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps_wr_en,
    input  logic [1:0] ps_wr_data,
    input  logic       cap_d1,
    input  logic       cap_d2,
    input  logic       cmd_wr_en,
    input  logic       cmd_io_en,
    input  logic       cmd_mem_en,
    output pstate_e    state_o,
    output logic       d0_uninit,
    output logic       acc_cfg,
    output logic       acc_io,
    output logic       acc_mem
);
    localparam int REC_MAX = (D2_REC_CYC > D3_REC_CYC) ? D2_REC_CYC : D3_REC_CYC;
    localparam int CW      = $clog2(REC_MAX + 2);

    pstate_e       state_q;
    pstate_e       tgt;
    logic [CW-1:0] rec_cnt;
    logic          busy;
    logic          legal;
    logic          take;
    logic          uninit_q;
    logic          io_q;
    logic          mem_q;

    assign busy = (rec_cnt != '0);

    // Legality of the requested move, given capabilities and the current state.
    always_comb begin
        tgt = pstate_e'(ps_wr_data);
        if (state_q == PS_D3) begin
            legal = (tgt == PS_D0);
        end else begin
            case (tgt)
                PS_D1:   legal = cap_d1;
                PS_D2:   legal = cap_d2;
                default: legal = 1'b1;
            endcase
        end
        take = ps_wr_en && !busy && legal && (tgt != state_q);
    end

    // State, recovery countdown and decode-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PS_D0;
            rec_cnt  <= '0;
            uninit_q <= 1'b1;
            io_q     <= 1'b0;
            mem_q    <= 1'b0;
        end else begin
            if (busy) begin
                rec_cnt <= rec_cnt - 1'b1;
            end
            if (cmd_wr_en && !busy) begin
                io_q  <= cmd_io_en;
                mem_q <= cmd_mem_en;
                if (state_q == PS_D0) begin
                    uninit_q <= 1'b0;
                end
            end
            if (take) begin
                state_q <= tgt;
                if (tgt == PS_D3) begin
                    io_q  <= 1'b0;
                    mem_q <= 1'b0;
                end
                if (state_q == PS_D3) begin
                    uninit_q <= 1'b1;
                    rec_cnt  <= CW'(D3_REC_CYC);
                end else if (state_q == PS_D2 && tgt == PS_D0) begin
                    rec_cnt  <= CW'(D2_REC_CYC);
                end
            end
        end
    end

    // Access qualifiers seen by the bus decoder.
    always_comb begin
        state_o   = state_q;
        d0_uninit = (state_q == PS_D0) && uninit_q;
        acc_cfg   = !busy;
        acc_io    = !busy && (state_q == PS_D0) && io_q;
        acc_mem   = !busy && (state_q == PS_D0) && mem_q;
    end
endmodule

// File: rtl/wake_collect.sv
// Per-source wake enables, sticky status and the active-low event pin.
// Assumes detector pulses last one cycle, and cfg_ok gates all software writes.
// The source at PATTERN_IDX is masked while the function is in D0.
module wake_collect #(
    parameter int NSRC        = 3,
    parameter int PATTERN_IDX = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_ok,
    input  logic            in_d0,
    input  logic            en_wr,
    input  logic [NSRC-1:0] en_data,
    input  logic            pin_wr,
    input  logic            pin_data,
    input  logic            clr_wr,
    input  logic [NSRC-1:0] clr_mask,
    input  logic [NSRC-1:0] wake_pulse,
    output logic [NSRC-1:0] sts,
    output logic            pme_n
);
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] sts_q;
    logic [NSRC-1:0] seen;
    logic            pin_q;

    // Enable register and pin enable, written only when configuration is allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pin_q <= 1'b0;
        end else begin
            if (en_wr && cfg_ok)  en_q  <= en_data;
            if (pin_wr && cfg_ok) pin_q <= pin_data;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam bit MASK_IN_D0 = (i == PATTERN_IDX);

        // Recognised event for this source.
        assign seen[i] = wake_pulse[i] && en_q[i] && !(MASK_IN_D0 && in_d0);

        // Sticky status bit: set wins over a write-one clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts_q[i] <= 1'b0;
            end else if (seen[i]) begin
                sts_q[i] <= 1'b1;
            end else if (clr_wr && cfg_ok && clr_mask[i]) begin
                sts_q[i] <= 1'b0;
            end
        end
    end

    assign sts   = sts_q;
    assign pme_n = ~(pin_q && |(sts_q & en_q));
endmodule

// File: rtl/pwr_wake_ctrl.sv
// Top level: power state tracking and wake event collection for one function.
// Assumes wake detectors and configuration decode sit outside this block.
module pwr_wake_ctrl
    import pwr_wake_pkg::*;
#(
    parameter int NSRC       = 3,
    parameter int D2_REC_CYC = 4,
    parameter int D3_REC_CYC = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ps_wr_en,
    input  logic [1:0]      ps_wr_data,
    input  logic            cap_d1,
    input  logic            cap_d2,
    input  logic            cmd_wr_en,
    input  logic            cmd_io_en,
    input  logic            cmd_mem_en,
    input  logic            wake_en_wr,
    input  logic [NSRC-1:0] wake_en_data,
    input  logic            pin_en_wr,
    input  logic            pin_en_data,
    input  logic            sts_clr_wr,
    input  logic [NSRC-1:0] sts_clr_mask,
    input  logic [NSRC-1:0] wake_pulse,
    output logic [1:0]      pwr_state,
    output logic            d0_uninit,
    output logic            acc_cfg,
    output logic            acc_io,
    output logic            acc_mem,
    output logic [NSRC-1:0] wake_sts,
    output logic            pme_n
);
    pstate_e st;

    pwr_state_fsm #(
        .D2_REC_CYC (D2_REC_CYC),
        .D3_REC_CYC (D3_REC_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ps_wr_en   (ps_wr_en),
        .ps_wr_data (ps_wr_data),
        .cap_d1     (cap_d1),
        .cap_d2     (cap_d2),
        .cmd_wr_en  (cmd_wr_en),
        .cmd_io_en  (cmd_io_en),
        .cmd_mem_en (cmd_mem_en),
        .state_o    (st),
        .d0_uninit  (d0_uninit),
        .acc_cfg    (acc_cfg),
        .acc_io     (acc_io),
        .acc_mem    (acc_mem)
    );

    wake_collect #(
        .NSRC        (NSRC),
        .PATTERN_IDX (SRC_PATTERN)
    ) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_ok     (acc_cfg),
        .in_d0      (st == PS_D0),
        .en_wr      (wake_en_wr),
        .en_data    (wake_en_data),
        .pin_wr     (pin_en_wr),
        .pin_data   (pin_en_data),
        .clr_wr     (sts_clr_wr),
        .clr_mask   (sts_clr_mask),
        .wake_pulse (wake_pulse),
        .sts        (wake_sts),
        .pme_n      (pme_n)
    );

    assign pwr_state = st;
endmodule

// File: rtl/pwr_wake_chk.sv
// Property checker for pwr_wake_ctrl, attached through bind.
// Watches only the top-level ports of the controller.
module pwr_wake_chk #(
    parameter int NSRC = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ps_wr_en,
    input logic [1:0]      ps_wr_data,
    input logic            cap_d1,
    input logic            cap_d2,
    input logic            sts_clr_wr,
    input logic [NSRC-1:0] sts_clr_mask,
    input logic [1:0]      pwr_state,
    input logic            acc_cfg,
    input logic            acc_io,
    input logic            acc_mem,
    input logic [NSRC-1:0] wake_sts,
    input logic            pme_n
);
    AST_SLEEP_NO_IO: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd0) |-> (!acc_io && !acc_mem)); // R5

    AST_D1_UNSUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_wr_en && ps_wr_data == 2'd1 && !cap_d1 && pwr_state != 2'd1) |=> (pwr_state != 2'd1)); // R3

    AST_D2_UNSUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_wr_en && ps_wr_data == 2'd2 && !cap_d2 && pwr_state != 2'd2) |=> (pwr_state != 2'd2)); // R3

    AST_D3_EXIT_ONLY_D0: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd3 && ps_wr_en && ps_wr_data != 2'd0) |=> (pwr_state == 2'd3)); // R4

    AST_PIN_NEEDS_STS: assert property (@(posedge clk) disable iff (!rst_n)
        !pme_n |-> (wake_sts != '0)); // R12

    AST_PAT_MASKED_D0: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && !wake_sts[0]) |=> !wake_sts[0]); // R10

    for (genvar k = 0; k < NSRC; k++) begin : g_sticky
        AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (wake_sts[k] && !(sts_clr_wr && acc_cfg && sts_clr_mask[k])) |=> wake_sts[k]); // R11
    end
endmodule

bind pwr_wake_ctrl pwr_wake_chk #(.NSRC(NSRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ps_wr_en     (ps_wr_en),
    .ps_wr_data   (ps_wr_data),
    .cap_d1       (cap_d1),
    .cap_d2       (cap_d2),
    .sts_clr_wr   (sts_clr_wr),
    .sts_clr_mask (sts_clr_mask),
    .pwr_state    (pwr_state),
    .acc_cfg      (acc_cfg),
    .acc_io       (acc_io),
    .acc_mem      (acc_mem),
    .wake_sts     (wake_sts),
    .pme_n        (pme_n)
);

// File: tb/pwr_wake_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_wake_ctrl_tb;
    localparam int NSRC = 3;
    localparam int D2R  = 3;
    localparam int D3R  = 9;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ps_wr_en = 1'b0;
    logic [1:0]      ps_wr_data = '0;
    logic            cap_d1 = 1'b0;
    logic            cap_d2 = 1'b0;
    logic            cmd_wr_en = 1'b0;
    logic            cmd_io_en = 1'b0;
    logic            cmd_mem_en = 1'b0;
    logic            wake_en_wr = 1'b0;
    logic [NSRC-1:0] wake_en_data = '0;
    logic            pin_en_wr = 1'b0;
    logic            pin_en_data = 1'b0;
    logic            sts_clr_wr = 1'b0;
    logic [NSRC-1:0] sts_clr_mask = '0;
    logic [NSRC-1:0] wake_pulse = '0;
    logic [1:0]      pwr_state;
    logic            d0_uninit, acc_cfg, acc_io, acc_mem, pme_n;
    logic [NSRC-1:0] wake_sts;

    int checks = 0;
    int errors = 0;

    // Bench reference state.
    int       m_ps, m_rec;
    bit       m_io, m_mem, m_uninit, m_pin;
    bit [2:0] m_en, m_sts;

    always #2.5 clk = ~clk;

    pwr_wake_ctrl #(.NSRC(NSRC), .D2_REC_CYC(D2R), .D3_REC_CYC(D3R)) u_dut (.*);

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit move_ok(int cur, int tgt, bit c1, bit c2);
        if (cur == 3) return tgt == 0;
        if (tgt == 1) return c1;
        if (tgt == 2) return c2;
        return 1'b1;
    endfunction

    function automatic bit exp_pin(bit pin, bit [2:0] en, bit [2:0] sts);
        return !(pin && ((en & sts) != 3'b0));
    endfunction

    task automatic model_reset();
        m_ps = 0; m_rec = 0; m_io = 0; m_mem = 0; m_uninit = 1;
        m_pin = 0; m_en = 0; m_sts = 0;
    endtask

    task automatic model_step();
        bit       ok;
        bit [2:0] set;
        ok  = (m_rec == 0);
        set = wake_pulse & m_en & ((m_ps != 0) ? 3'b111 : 3'b110);
        if (ok && sts_clr_wr) m_sts = m_sts & ~sts_clr_mask;
        m_sts = m_sts | set;
        if (ok && wake_en_wr) m_en = wake_en_data;
        if (ok && pin_en_wr) m_pin = pin_en_data;
        if (m_rec > 0) m_rec--;
        if (ok && cmd_wr_en) begin
            m_io = cmd_io_en; m_mem = cmd_mem_en;
            if (m_ps == 0) m_uninit = 0;
        end
        if (ok && ps_wr_en && int'(ps_wr_data) != m_ps && move_ok(m_ps, int'(ps_wr_data), cap_d1, cap_d2)) begin
            if (ps_wr_data == 2'd3) begin m_io = 0; m_mem = 0; end
            if (m_ps == 3) begin m_uninit = 1; m_rec = D3R; end
            else if (m_ps == 2 && ps_wr_data == 2'd0) m_rec = D2R;
            m_ps = int'(ps_wr_data);
        end
    endtask

    task automatic compare_all();
        chk("R2 R3 R4", "pwr_state", int'(pwr_state), m_ps);
        chk("R6 R8", "d0_uninit", int'(d0_uninit), int'(m_ps == 0 && m_uninit));
        chk("R7", "acc_cfg", int'(acc_cfg), int'(m_rec == 0));
        chk("R5 R6 R7", "acc_io", int'(acc_io), int'(m_rec == 0 && m_ps == 0 && m_io));
        chk("R5 R6 R7", "acc_mem", int'(acc_mem), int'(m_rec == 0 && m_ps == 0 && m_mem));
        chk("R9 R10 R11", "wake_sts", int'(wake_sts), int'(m_sts));
        chk("R12", "pme_n", int'(pme_n), int'(exp_pin(m_pin, m_en, m_sts)));
    endtask

    task automatic quiet();
        ps_wr_en = 0; cmd_wr_en = 0; wake_en_wr = 0; pin_en_wr = 0;
        sts_clr_wr = 0; wake_pulse = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        quiet();
    endtask

    task automatic ps_write(int code);
        ps_wr_en = 1; ps_wr_data = 2'(code);
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1", "pwr_state", int'(pwr_state), 0);
        chk("R1", "d0_uninit", int'(d0_uninit), 1);
        chk("R1", "acc_cfg", int'(acc_cfg), 1);
        chk("R1", "acc_io", int'(acc_io), 0);
        chk("R1", "acc_mem", int'(acc_mem), 0);
        chk("R1", "wake_sts", int'(wake_sts), 0);
        chk("R1", "pme_n", int'(pme_n), 1);

        // R6: command write in D0
        cmd_wr_en = 1; cmd_io_en = 1; cmd_mem_en = 1; tick();
        // R9/R12: enables on
        wake_en_wr = 1; wake_en_data = 3'b111; pin_en_wr = 1; pin_en_data = 1; tick();
        // R10: pattern pulse in D0 is masked
        wake_pulse = 3'b001; tick();
        // R9: magic pulse sets bit 1
        wake_pulse = 3'b010; tick();
        // R11: set and clear on same bit, then a plain clear
        wake_pulse = 3'b010; sts_clr_wr = 1; sts_clr_mask = 3'b010; tick();
        sts_clr_wr = 1; sts_clr_mask = 3'b111; tick();
        // R3: unsupported D1/D2 ignored
        cap_d1 = 0; cap_d2 = 0; ps_write(1); ps_write(2);
        // R7: D1 and back with no recovery
        cap_d1 = 1; ps_write(1);
        wake_pulse = 3'b001; tick();
        ps_write(0);
        // R7: D2 recovery, with a write attempt inside the window
        cap_d2 = 1; ps_write(2); ps_write(0);
        ps_write(3);
        for (int i = 0; i < D2R; i++) tick();
        // R8/R4: D3 clears decode, exits only to D0
        cmd_wr_en = 1; cmd_io_en = 1; cmd_mem_en = 0; tick();
        ps_write(3); ps_write(1); ps_write(2);
        wake_pulse = 3'b100; tick();
        ps_write(0);
        for (int i = 0; i < D3R + 1; i++) tick();

        // Random traffic
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(0, 63) == 0) cap_d1 = 1'($urandom);
            if ($urandom_range(0, 63) == 0) cap_d2 = 1'($urandom);
            ps_wr_en     = ($urandom_range(0, 7) == 0);
            ps_wr_data   = 2'($urandom);
            cmd_wr_en    = ($urandom_range(0, 9) == 0);
            cmd_io_en    = 1'($urandom);
            cmd_mem_en   = 1'($urandom);
            wake_en_wr   = ($urandom_range(0, 15) == 0);
            wake_en_data = 3'($urandom);
            pin_en_wr    = ($urandom_range(0, 15) == 0);
            pin_en_data  = 1'($urandom);
            sts_clr_wr   = ($urandom_range(0, 7) == 0);
            sts_clr_mask = 3'($urandom);
            wake_pulse   = 3'($urandom) & 3'($urandom);
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule